// File: doc/BRIEF.md
# Compare/Capture Timer Array

This block is a 16-bit time base that serves a set of compare/capture channels (two by default). The time base advances on one of four tick sources: the system clock divided by six, the system clock divided by two, an overflow strobe from a neighbouring timer, or rising edges of an external pin. Software starts and stops it through a run bit and can load it at any time. When it wraps from its all-ones value, an overflow flag is set.

Each channel has a mode register and a 16-bit compare register. The compare register is split into a low and a high byte. A channel can capture the time base on the rising edge, the falling edge or both edges of its input pin. It can flag the moment the time base reaches its compare value, or toggle its output pin at that moment. It can also drive an 8-bit pulse-width signal. In pulse-width mode the high compare byte acts as a staging copy, and it moves into the low byte only when the low counter byte wraps, so duty-cycle updates never produce a partial period. All flags share one interrupt line, and each flag has its own enable.

Software reaches every register through a byte-wide register bus. Writes take effect at the clock edge. Reads are combinational from the current address.

Top module: `cmpcap_array`

## Requirements
- R1: After reset the counter is 0000h, the status register (offset 1) reads 00h, the interrupt line is low and every channel output is low.
- R2: Configuration register (offset 0) bits [1:0] select the tick source: 00 gives one count every 6 system clocks and 01 one count every 2. The first count lands on the 6th (or 2nd) clock edge after the edge that writes the run bit (status bit 0) to 1.
- R3: Source 10 counts one per cycle of the neighbouring-timer strobe, and source 11 counts one per rising edge of the external pin, seen through a synchronizer. No count happens while the system-clock enable is low or while the run bit is 0. Counter bytes are readable and writable at offsets 2 (low) and 3 (high).
- R4: On a count from FFFFh to 0000h, status bit 7 is set. A status write with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged, so software can never set it.
- R5: Channel n sits at offsets 4+4n (mode), 5+4n (compare low) and 6+4n (compare high). Mode bit 5 enables capture on rising edges and bit 4 on falling edges. A detected edge copies the counter into the compare bytes and sets the channel flag (status bit n+1) on the third clock edge after the pin changes.
- R6: With mode bit 3 (match) and bit 6 (compare enable) set, the channel flag is set on the edge at which the counter steps onto the 16-bit compare value.
- R7: With mode bits 2, 3 and 6 set, the channel output toggles at each such match.
- R8: With mode bit 1 (pulse width) and bit 6 set, the channel output is high while the low counter byte is at or above the compare low byte, and low otherwise.
- R9: In pulse-width mode the compare low byte keeps its value until the low counter byte counts from FFh to 00h, and it is then loaded from the compare high byte.
- R10: A write of the compare low byte clears mode bit 6, and a write of the compare high byte sets it.
- R11: The interrupt line is high exactly when the overflow flag is set with configuration bit 2 set, or when a channel flag is set with that channel's mode bit 0 set. Channel flags are cleared by a status write with the matching bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_ce | input | 1 | System clock enable; gates every tick source |
| t0_ovf_strobe | input | 1 | One-cycle overflow strobe from a neighbouring timer |
| ext_clk_pin | input | 1 | External count pin, synchronized inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ch_pin_in | input | NUM_CH | Capture input pin per channel |
| ch_pin_out | output | NUM_CH | Toggle or pulse-width output per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong prescaler phase or tick source shows up as a counter readback that is off by one or more counts, within one prescale period of the run write. A bad compare or shadow byte shows up on the channel pin immediately, because the pulse-width output is combinational from the counter. It also shows up in the readable compare low byte one edge after the low-byte wrap. Errors in the capture path or the synchronizer show up as a flag that rises one edge early or late, or as a captured value that differs from a counter the bench has stopped. Flag and interrupt faults reach the status byte and the irq pin on the edge after the event.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'd0,
    SRC_DIV_FAST = 2'd1,
    SRC_T0       = 2'd2,
    SRC_EXT      = 2'd3
  } clk_src_e;

  // packed MSB first: bit6 cmp_en .. bit0 irq_en
  typedef struct packed {
    logic cmp_en;
    logic cap_rise;
    logic cap_fall;
    logic match;
    logic toggle;
    logic pwm;
    logic irq_en;
  } ch_mode_t;

  function automatic logic f_hits(input logic [CNT_W-1:0] next_cnt,
                                  input logic [CNT_W-1:0] cmp);
    return next_cnt == cmp;
  endfunction

  function automatic logic f_pwm_high(input logic [BYTE_W-1:0] lo_cnt,
                                      input logic [BYTE_W-1:0] thr);
    return lo_cnt >= thr;
  endfunction

  function automatic logic f_edge(input logic rise_en, input logic fall_en,
                                  input logic cur, input logic prev);
    return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  endfunction
endpackage

// File: rtl/cmpcap_timebase.sv
module cmpcap_timebase
  import cmpcap_pkg::*;
#(
  parameter int DIV_SLOW = 6,
  parameter int DIV_FAST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_ce,
  input  logic              run,
  input  clk_src_e          src,
  input  logic              t0_strobe,
  input  logic              ext_pin,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              step,
  output logic              lo_wrap,
  output logic              full_wrap
);
  localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [PW-1:0] presc, limit;
  logic          presc_hit, tick;
  logic [2:0]    ext_sync;
  logic          ext_rise;

  assign limit     = (src == SRC_DIV_FAST) ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign presc_hit = sys_ce && (presc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  presc <= '0;
    else if (!run || src == SRC_T0 || src == SRC_EXT) presc <= '0;
    else if (sys_ce)                             presc <= presc_hit ? '0 : presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_sync <= '0;
    else if (sys_ce) ext_sync <= {ext_sync[1:0], ext_pin};
  end
  assign ext_rise = ext_sync[1] & ~ext_sync[2];

  always_comb begin
    unique case (src)
      SRC_DIV_SLOW,
      SRC_DIV_FAST: tick = presc_hit;
      SRC_T0:       tick = sys_ce & t0_strobe;
      default:      tick = sys_ce & ext_rise;
    endcase
  end

  assign step      = run & tick;
  assign lo_wrap   = step & (&cnt[BYTE_W-1:0]);
  assign full_wrap = step & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (we_lo || we_hi) begin
      if (we_lo) cnt[BYTE_W-1:0]     <= wdata;
      if (we_hi) cnt[CNT_W-1:BYTE_W] <= wdata;
    end else if (step) cnt <= cnt + 1'b1;
  end

  // R3: a tick without a software write advances by exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we_lo && !we_hi) |=> cnt == $past(cnt) + 1'b1);

  // R3: stopped and unwritten counter holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we_lo && !we_hi) |=> $stable(cnt));
endmodule

// File: rtl/cmpcap_channel.sv
module cmpcap_channel
  import cmpcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              step,
  input  logic              lo_wrap,
  input  logic              pin_in,
  input  logic              flag_clr,
  output ch_mode_t          mode_q,
  output logic [BYTE_W-1:0] cmp_lo,
  output logic [BYTE_W-1:0] cmp_hi,
  output logic              flag,
  output logic              pin_out,
  output logic              irq_req
);
  logic [2:0] pin_sync;
  logic       edge_seen, pwm_act, match_act, match_evt, tog_evt, cap_evt, tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sync <= '0;
    else        pin_sync <= {pin_sync[1:0], pin_in};
  end

  assign edge_seen = f_edge(mode_q.cap_rise, mode_q.cap_fall, pin_sync[1], pin_sync[2]);
  assign pwm_act   = mode_q.pwm & mode_q.cmp_en;
  assign match_act = mode_q.match & mode_q.cmp_en & ~mode_q.pwm;
  assign match_evt = match_act & step & f_hits(cnt + 1'b1, {cmp_hi, cmp_lo});
  assign tog_evt   = match_evt & mode_q.toggle;
  assign cap_evt   = ~pwm_act & ~match_act & edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= ch_mode_t'(wdata[6:0]);
    else if (lo_we)   mode_q.cmp_en <= 1'b0;
    else if (hi_we)   mode_q.cmp_en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cmp_lo <= '0;
    else if (lo_we)               cmp_lo <= wdata;
    else if (cap_evt)             cmp_lo <= cnt[BYTE_W-1:0];
    else if (pwm_act && lo_wrap)  cmp_lo <= cmp_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_hi <= '0;
    else if (hi_we)   cmp_hi <= wdata;
    else if (cap_evt) cmp_hi <= cnt[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag <= 1'b0;
    else if (match_evt || cap_evt) flag <= 1'b1;
    else if (flag_clr)            flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (tog_evt) tog_q <= ~tog_q;
  end

  assign pin_out = pwm_act ? f_pwm_high(cnt[BYTE_W-1:0], cmp_lo) : tog_q;
  assign irq_req = flag & mode_q.irq_en;

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !lo_we && !hi_we) |=> flag && {cmp_hi, cmp_lo} == $past(cnt));

  p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag);

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_evt && !mode_we && !lo_we) |=> pin_out != $past(pin_out));

  p_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_act && lo_wrap && !lo_we) |=> cmp_lo == $past(cmp_hi));

  p_cmpen_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !mode_we) |=> !mode_q.cmp_en);

  p_cmpen_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !mode_we) |=> mode_q.cmp_en);
endmodule

// File: rtl/cmpcap_array.sv
module cmpcap_array
  import cmpcap_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 4,
  parameter int DIV_SLOW = 6,
  parameter int DIV_FAST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_ce,
  input  logic              t0_ovf_strobe,
  input  logic              ext_clk_pin,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NUM_CH-1:0] ch_pin_in,
  output logic [NUM_CH-1:0] ch_pin_out,
  output logic              irq
);
  localparam int A_CFG     = 0;
  localparam int A_STAT    = 1;
  localparam int A_CNT_LO  = 2;
  localparam int A_CNT_HI  = 3;
  localparam int CH_BASE   = 4;
  localparam int CH_STRIDE = 4;
  localparam int OVF_BIT   = 7;

  clk_src_e          src_q;
  logic              ovf_ie, run, ovf_flag;
  logic              cfg_we, stat_we, cnt_lo_we, cnt_hi_we;
  logic [CNT_W-1:0]  cnt;
  logic              step, lo_wrap, full_wrap;
  ch_mode_t          ch_mode [NUM_CH];
  logic [BYTE_W-1:0] ch_lo [NUM_CH];
  logic [BYTE_W-1:0] ch_hi [NUM_CH];
  logic [NUM_CH-1:0] ch_flag, ch_irq;

  assign cfg_we    = reg_we && reg_addr == ADDR_W'(A_CFG);
  assign stat_we   = reg_we && reg_addr == ADDR_W'(A_STAT);
  assign cnt_lo_we = reg_we && reg_addr == ADDR_W'(A_CNT_LO);
  assign cnt_hi_we = reg_we && reg_addr == ADDR_W'(A_CNT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_DIV_SLOW;
      ovf_ie <= 1'b0;
    end else if (cfg_we) begin
      src_q  <= clk_src_e'(reg_wdata[1:0]);
      ovf_ie <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= 1'b0;
    else if (stat_we) run <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ovf_flag <= 1'b0;
    else if (full_wrap)                      ovf_flag <= 1'b1;
    else if (stat_we && !reg_wdata[OVF_BIT]) ovf_flag <= 1'b0;
  end

  cmpcap_timebase #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) tb_i (
    .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .run(run), .src(src_q),
    .t0_strobe(t0_ovf_strobe), .ext_pin(ext_clk_pin),
    .we_lo(cnt_lo_we), .we_hi(cnt_hi_we), .wdata(reg_wdata),
    .cnt(cnt), .step(step), .lo_wrap(lo_wrap), .full_wrap(full_wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * i;
    logic mode_we, lo_we, hi_we, flag_clr;
    assign mode_we  = reg_we && reg_addr == ADDR_W'(BASE);
    assign lo_we    = reg_we && reg_addr == ADDR_W'(BASE + 1);
    assign hi_we    = reg_we && reg_addr == ADDR_W'(BASE + 2);
    assign flag_clr = stat_we && !reg_wdata[i+1];

    cmpcap_channel ch_i (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .lo_we(lo_we), .hi_we(hi_we),
      .wdata(reg_wdata), .cnt(cnt), .step(step), .lo_wrap(lo_wrap),
      .pin_in(ch_pin_in[i]), .flag_clr(flag_clr), .mode_q(ch_mode[i]),
      .cmp_lo(ch_lo[i]), .cmp_hi(ch_hi[i]), .flag(ch_flag[i]),
      .pin_out(ch_pin_out[i]), .irq_req(ch_irq[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_W'(A_CFG):    reg_rdata = {5'b0, ovf_ie, src_q};
      ADDR_W'(A_STAT): begin
        reg_rdata[0]        = run;
        reg_rdata[NUM_CH:1] = ch_flag;
        reg_rdata[OVF_BIT]  = ovf_flag;
      end
      ADDR_W'(A_CNT_LO): reg_rdata = cnt[BYTE_W-1:0];
      ADDR_W'(A_CNT_HI): reg_rdata = cnt[CNT_W-1:BYTE_W];
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * i))     reg_rdata = {1'b0, ch_mode[i]};
          if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + 1)) reg_rdata = ch_lo[i];
          if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + 2)) reg_rdata = ch_hi[i];
        end
      end
    endcase
  end

  assign irq = (ovf_flag & ovf_ie) | (|ch_irq);

  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_wrap |=> ovf_flag);

  p_ovf_hw_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(full_wrap));

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && ch_flag == '0) |-> !irq);
endmodule

// File: tb/cmpcap_array_tb_top.sv
module cmpcap_array_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_ce = 1'b1;
  logic       t0 = 1'b0;
  logic       ext = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cin = '0;
  logic [1:0] cout;
  logic       irq;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cmpcap_array dut_i (
    .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .t0_ovf_strobe(t0),
    .ext_clk_pin(ext), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .ch_pin_in(cin), .ch_pin_out(cout), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(4'd2, lo);
    rd(4'd3, hi);
    c = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wr(4'd2, c[7:0]);
    wr(4'd3, c[15:8]);
  endtask

  task automatic pulse_t0();
    @(negedge clk); t0 = 1'b1;
    @(negedge clk); t0 = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] c; logic [7:0] s;
    rd_cnt(c);   check("R1 counter", c, 16'h0000);
    rd(4'd1, s); check("R1 status", {8'h0, s}, 16'h0000);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 pins", {14'h0, cout}, 16'h0);
  endtask

  task automatic t_dividers();
    logic [15:0] c;
    wr(4'd1, 8'h00); wr(4'd0, 8'h00); set_cnt(16'h0000);
    wr(4'd1, 8'h01);
    repeat (11) @(negedge clk);
    rd_cnt(c); check("R2 div6 edge11", c, 16'd1);
    @(negedge clk);
    rd_cnt(c); check("R2 div6 edge12", c, 16'd2);
    wr(4'd1, 8'h00); wr(4'd0, 8'h01); set_cnt(16'h0000);
    wr(4'd1, 8'h01);
    repeat (9) @(negedge clk);
    rd_cnt(c); check("R2 div2 edge9", c, 16'd4);
    @(negedge clk);
    rd_cnt(c); check("R2 div2 edge10", c, 16'd5);
  endtask

  task automatic t_sources();
    logic [15:0] c;
    wr(4'd1, 8'h00); wr(4'd0, 8'h03); set_cnt(16'h0000); wr(4'd1, 8'h01);
    for (int k = 0; k < 4; k++) begin
      ext = 1'b1; repeat (3) @(negedge clk);
      ext = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd_cnt(c); check("R3 ext edges", c, 16'd4);
    wr(4'd0, 8'h02);
    pulse_t0();
    rd_cnt(c); check("R3 t0 strobe", c, 16'd5);
    sys_ce = 1'b0; pulse_t0(); sys_ce = 1'b1;
    rd_cnt(c); check("R3 sys_ce low", c, 16'd5);
    wr(4'd1, 8'h00); pulse_t0();
    rd_cnt(c); check("R3 run low", c, 16'd5);
  endtask

  task automatic t_overflow();
    logic [15:0] c; logic [7:0] s;
    wr(4'd0, 8'h06); wr(4'd1, 8'h01); set_cnt(16'hFFFF);
    pulse_t0();
    rd_cnt(c); check("R4 wrap count", c, 16'h0000);
    rd(4'd1, s); check("R4 flag set", {15'h0, s[7]}, 16'h1);
    check("R11 ovf irq", {15'h0, irq}, 16'h1);
    wr(4'd1, 8'h01);
    rd(4'd1, s); check("R4 flag cleared", {15'h0, s[7]}, 16'h0);
    check("R11 irq drops", {15'h0, irq}, 16'h0);
    wr(4'd1, 8'h81);
    rd(4'd1, s); check("R4 sw cannot set", {15'h0, s[7]}, 16'h0);
    wr(4'd0, 8'h02); set_cnt(16'hFFFF); pulse_t0();
    rd(4'd1, s); check("R4 flag again", {15'h0, s[7]}, 16'h1);
    check("R11 ovf masked", {15'h0, irq}, 16'h0);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_match();
    logic [7:0] s;
    wr(4'd0, 8'h01); set_cnt(16'h00F0);
    wr(4'd4, 8'h08); wr(4'd5, 8'hF5); wr(4'd6, 8'h00);
    wr(4'd1, 8'h01);
    repeat (9) @(negedge clk);
    rd(4'd1, s); check("R6 before match", {15'h0, s[1]}, 16'h0);
    @(negedge clk);
    rd(4'd1, s); check("R6 at match", {15'h0, s[1]}, 16'h1);
    check("R11 match masked", {15'h0, irq}, 16'h0);
    wr(4'd4, 8'h49);
    check("R11 match irq", {15'h0, irq}, 16'h1);
    wr(4'd1, 8'h00);
    check("R11 cleared", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_toggle();
    logic [7:0] s;
    wr(4'd0, 8'h02); wr(4'd1, 8'h01); set_cnt(16'h0010);
    wr(4'd4, 8'h0C); wr(4'd5, 8'h12); wr(4'd6, 8'h00);
    rd(4'd4, s); check("R10 hi sets enable", {8'h0, s}, 16'h004C);
    pulse_t0(); check("R7 before match", {15'h0, cout[0]}, 16'h0);
    pulse_t0(); check("R7 first toggle", {15'h0, cout[0]}, 16'h1);
    rd(4'd1, s); check("R6 toggle flag", {15'h0, s[1]}, 16'h1);
    pulse_t0(); check("R7 holds", {15'h0, cout[0]}, 16'h1);
    set_cnt(16'h0011);
    pulse_t0(); check("R7 second toggle", {15'h0, cout[0]}, 16'h0);
    wr(4'd1, 8'h01);
  endtask

  task automatic t_pwm();
    logic [7:0] s;
    wr(4'd0, 8'h02); wr(4'd1, 8'h01);
    wr(4'd8, 8'h02); wr(4'd9, 8'h40); wr(4'd10, 8'h40);
    set_cnt(16'h00FE);
    check("R8 above threshold", {15'h0, cout[1]}, 16'h1);
    set_cnt(16'h0010);
    check("R8 below threshold", {15'h0, cout[1]}, 16'h0);
    wr(4'd10, 8'h20); set_cnt(16'h0030);
    check("R9 no early reload pin", {15'h0, cout[1]}, 16'h0);
    rd(4'd9, s); check("R9 low byte kept", {8'h0, s}, 16'h0040);
    set_cnt(16'h00FF); pulse_t0();
    rd(4'd9, s); check("R9 reload on wrap", {8'h0, s}, 16'h0020);
    check("R8 after wrap", {15'h0, cout[1]}, 16'h0);
    set_cnt(16'h011F); pulse_t0();
    check("R8 at new threshold", {15'h0, cout[1]}, 16'h1);
    wr(4'd9, 8'h50);
    rd(4'd8, s); check("R10 lo clears enable", {8'h0, s}, 16'h0002);
    check("R10 pwm off pin", {15'h0, cout[1]}, 16'h0);
  endtask

  task automatic t_capture();
    logic [7:0] s, lo, hi;
    wr(4'd1, 8'h00); set_cnt(16'h1234); wr(4'd8, 8'h20);
    @(negedge clk); cin[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd1, s); check("R5 rise not yet", {15'h0, s[2]}, 16'h0);
    @(negedge clk);
    rd(4'd1, s); check("R5 rise flag", {15'h0, s[2]}, 16'h1);
    rd(4'd9, lo); rd(4'd10, hi);
    check("R5 rise value", {hi, lo}, 16'h1234);
    wr(4'd1, 8'h00); set_cnt(16'h5555);
    @(negedge clk); cin[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'd1, s); check("R5 fall ignored flag", {15'h0, s[2]}, 16'h0);
    rd(4'd9, lo); check("R5 fall ignored value", {8'h0, lo}, 16'h0034);
    wr(4'd8, 8'h30);
    @(negedge clk); cin[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd9, lo); rd(4'd10, hi);
    check("R5 both edges value", {hi, lo}, 16'h5555);
    rd(4'd1, s); check("R5 both edges flag", {15'h0, s[2]}, 16'h1);
    wr(4'd1, 8'h00);
    @(negedge clk); cin[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd1, s); check("R5 falling in both mode", {15'h0, s[2]}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dividers();
    t_sources();
    t_overflow();
    t_match();
    t_toggle();
    t_pwm();
    t_capture();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule